// File: doc/BRIEF.md
# Watchdog Timer with Sequenced Kick Check

This block is a general-purpose up/down counter with a prescaler that can also act as a system watchdog. Software sets it up through three write-only registers: a control word, a load value and a clear register. Each register is selected by a small address on one write port. In plain timer mode, reaching the terminal count raises an interrupt, which stays set until software writes the clear register. In watchdog mode, the same event becomes an expiry. An expiry produces either a one-cycle reset pulse or, if chosen, the interrupt.

A hardened kick option can be turned on. While it is on, every write to the clear register in watchdog mode must carry the value an internal 8-bit linear feedback shift register currently holds. Software seeds that register through the clear register before it enables the watchdog. The register cannot be read back, so software has to compute the same sequence. A correct kick restarts the timeout and advances the sequence. A wrong kick, or any kick while the sequence state is zero, produces the reset pulse at once.

Top module: `wdog_lfsr_timer`

## Requirements
- R1: After reset, `countVal`, `irqOut` and `resetPulse` are all zero, and the control word, load value and sequence state are all zero.
- R2: When `wrEn` is high, `wrSel` chooses the register: 0 is the control word, 1 is the load value, 2 is the clear register, and 3 has no effect. A load write also copies the value into the counter. The control word bits are: 8 count up, 7 enable, 6 periodic, 5 watchdog, 4 hardened kick, 3:2 prescale, 1 expiry-to-interrupt.
- R3: The counter moves one step per prescaler tick. Prescale code 00 or 11 gives one tick per `clkEn` cycle, 01 gives one tick every 16th, and 10 gives one tick every 256th. The prescaler restarts whenever the control word is written or the timer is disabled, and no tick occurs in the cycle of a control write.
- R4: With bit 8 clear, the counter counts down and its terminal count is zero. With bit 8 set, it counts up and its terminal count is all ones.
- R5: A tick at terminal count reloads the load value in periodic mode, and also whenever the watchdog is active. In free-running mode the counter wraps around its full range.
- R6: Outside watchdog mode, a tick at terminal count sets `irqOut`, which holds until a clear write. If both happen in the same cycle, the set wins.
- R7: With watchdog mode active (enable and watchdog bits set), an expiry that no valid kick in the same cycle cancels pulses `resetPulse` for one cycle on the next edge. If bit 1 is set, the expiry sets `irqOut` instead.
- R8: With the hardened kick option off and watchdog mode active, any clear write reloads the counter, clears `irqOut`, and gives no reset.
- R9: While watchdog mode is not active, a clear write loads its low 8 bits as the sequence seed and clears `irqOut`.
- R10: With the hardened kick option on, a clear write equal to the sequence state reloads the counter, clears `irqOut`, and advances the state: shift left one place and, if the bit shifted out was 1, XOR with 0x63. From seed 0xAA, the accepted values run 0xAA, 0x37, 0x6E, 0xDC.
- R11: With the hardened kick option on, a clear write that does not match gives the reset pulse on the next edge, before any expiry. It leaves the counter and the sequence state as they were.
- R12: When the sequence state is 0x00, every clear write in hardened watchdog mode gives the reset pulse, whatever value it carries.
- R13: With the enable bit clear, the counter holds, except on load writes, and no expiry or interrupt arises from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| clkEn | input | 1 | Source clock enable feeding the prescaler |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 2 | Register select (0 control, 1 load, 2 clear, 3 none) |
| wrData | input | 16 | Write data |
| countVal | output | CNT_W | Current counter value |
| irqOut | output | 1 | Sticky timer interrupt |
| resetPulse | output | 1 | One-cycle watchdog reset request |

## Verification
The bench builds the block with an 8-bit counter and keeps the 16 and 256 prescale steps. With the short counter, free-running wrap in both directions and up-count terminal events happen within a few hundred cycles, and the /256 prescale still shows several ticks. A behavioural model runs alongside on every clock. It covers gated `clkEn`, the seeding of the sequence and the 0xAA, 0x37, 0x6E accepted kicks followed by a refused 0x66, a zero seed, and expiry routed either to reset or to the interrupt.

// File: rtl/wdog_lfsr_timer_pkg.sv
package wdog_lfsr_timer_pkg;

  localparam int DATA_W = 16;
  localparam int CFG_LSB = 1;   // control word occupies wrData[8:1]
  localparam int CFG_W = 8;

  typedef enum logic [1:0] {
    SEL_CTRL  = 2'd0,
    SEL_LOAD  = 2'd1,
    SEL_CLEAR = 2'd2,
    SEL_NONE  = 2'd3
  } wrSel_e;

  // Packed in the same order as wrData[8:1]
  typedef struct packed {
    logic       up;
    logic       en;
    logic       periodic;
    logic       wd;
    logic       secure;
    logic [1:0] pre;
    logic       irqOpt;
  } cfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic countUp;
    logic step;
    logic reload;
    logic takeLoad;
    logic seedLfsr;
    logic stepLfsr;
  } dpCmd_t;

endpackage

// File: rtl/wdog_lfsr_timer_dp.sv
module wdog_lfsr_timer_dp
  import wdog_lfsr_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int LFSR_W = 8,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = 8'h63
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCmd_t            cmd,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  countVal,
  output logic              atTerm,
  output logic              lfsrHit,
  output logic              lfsrZero
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0]  cnt;
  logic [CNT_W-1:0]  loadVal;
  logic [LFSR_W-1:0] lfsr;
  logic [LFSR_W-1:0] lfsrNext;

  // Galois-style step: shift left, fold the outgoing bit into the taps
  assign lfsrNext[0] = LFSR_TAPS[0] & lfsr[LFSR_W-1];
  for (genvar g = 1; g < LFSR_W; g++) begin : gTap
    assign lfsrNext[g] = lfsr[g-1] ^ (LFSR_TAPS[g] & lfsr[LFSR_W-1]);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt     <= '0;
      loadVal <= '0;
    end else if (cmd.takeLoad) begin
      loadVal <= wrData[CNT_W-1:0];
      cnt     <= wrData[CNT_W-1:0];
    end else if (cmd.reload) begin
      cnt <= loadVal;
    end else if (cmd.step) begin
      cnt <= cmd.countUp ? cnt + CNT_ONE : cnt - CNT_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             lfsr <= '0;
    else if (cmd.seedLfsr) lfsr <= wrData[LFSR_W-1:0];
    else if (cmd.stepLfsr) lfsr <= lfsrNext;
  end

  assign countVal = cnt;
  assign atTerm   = cmd.countUp ? (cnt == CNT_MAX) : (cnt == '0);
  assign lfsrZero = (lfsr == '0);
  assign lfsrHit  = (wrData[LFSR_W-1:0] == lfsr) && !lfsrZero;

  // R3: the counter only moves when the control side asked for it
  assert_count_moves_on_cmd_R3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(cnt) |-> $past(cmd.step | cmd.reload | cmd.takeLoad));

  // R9: sequence state only changes on a seed or an accepted kick
  assert_lfsr_changes_on_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(lfsr) |-> $past(cmd.seedLfsr | cmd.stepLfsr));

endmodule

// File: rtl/wdog_lfsr_timer_ctrl.sv
module wdog_lfsr_timer_ctrl
  import wdog_lfsr_timer_pkg::*;
#(
  parameter int DIV1_LOG = 4,
  parameter int DIV2_LOG = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEn,
  input  logic             wrEn,
  input  logic [1:0]       wrSel,
  input  logic [CFG_W-1:0] cfgData,
  input  logic             atTerm,
  input  logic             lfsrHit,
  input  logic             lfsrZero,
  output dpCmd_t           cmd,
  output logic             irqOut,
  output logic             resetPulse
);

  cfg_t cfg;
  logic [DIV2_LOG-1:0] preCnt;
  logic preHit, tick, timeout;
  logic cfgWr, loadWr, clrWr;
  logic wdActive, kick, goodKick, badKick, expire;
  logic irqSet, rstNext;

  assign cfgWr  = wrEn && (wrSel == SEL_CTRL);
  assign loadWr = wrEn && (wrSel == SEL_LOAD);
  assign clrWr  = wrEn && (wrSel == SEL_CLEAR);

  always_ff @(posedge clk) begin
    if (!rstN)      cfg <= '0;
    else if (cfgWr) cfg <= cfg_t'(cfgData);
  end

  // Prescaler
  always_ff @(posedge clk) begin
    if (!rstN || cfgWr || !cfg.en) preCnt <= '0;
    else if (clkEn)                preCnt <= preCnt + 1'b1;
  end

  always_comb begin
    unique case (cfg.pre)
      2'b01:   preHit = &preCnt[DIV1_LOG-1:0];
      2'b10:   preHit = &preCnt;
      default: preHit = 1'b1;
    endcase
  end

  assign tick    = clkEn && cfg.en && !cfgWr && preHit;
  assign timeout = tick && atTerm;

  // Watchdog decode
  assign wdActive = cfg.en && cfg.wd;
  assign kick     = clrWr && wdActive;
  assign goodKick = kick && (!cfg.secure || lfsrHit);
  assign badKick  = kick && cfg.secure && !lfsrHit;
  assign expire   = timeout && wdActive && !goodKick;
  assign rstNext  = badKick || (expire && !cfg.irqOpt);
  assign irqSet   = (timeout && !wdActive) || (expire && cfg.irqOpt);

  always_comb begin
    cmd          = '0;
    cmd.countUp  = cfg.up;
    cmd.takeLoad = loadWr;
    cmd.reload   = goodKick || (timeout && (cfg.periodic || wdActive));
    cmd.step     = tick;
    cmd.seedLfsr = clrWr && !wdActive;
    cmd.stepLfsr = goodKick && cfg.secure;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqOut     <= 1'b0;
      resetPulse <= 1'b0;
    end else begin
      resetPulse <= rstNext;
      if (irqSet)     irqOut <= 1'b1;
      else if (clrWr) irqOut <= 1'b0;
    end
  end

  // R11: a refused kick always produces the reset pulse next cycle
  assert_bad_kick_resets_R11: assert property (@(posedge clk) disable iff (!rstN)
    (kick && cfg.secure && !lfsrHit) |=> resetPulse);

  // R12: zero sequence state refuses every kick
  assert_zero_state_resets_R12: assert property (@(posedge clk) disable iff (!rstN)
    (kick && cfg.secure && lfsrZero) |=> resetPulse);

  // R13: a disabled timer never ticks
  assert_disabled_no_tick_R13: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.en |-> !tick);

  // R6: a clear write without a competing set leaves the interrupt low
  assert_clear_drops_irq_R6: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && !irqSet) |=> !irqOut);

endmodule

// File: rtl/wdog_lfsr_timer.sv
module wdog_lfsr_timer
  import wdog_lfsr_timer_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int DIV1_LOG = 4,
  parameter int DIV2_LOG = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkEn,
  input  logic              wrEn,
  input  logic [1:0]        wrSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [CNT_W-1:0]  countVal,
  output logic              irqOut,
  output logic              resetPulse
);

  dpCmd_t cmd;
  logic atTerm, lfsrHit, lfsrZero;

  wdog_lfsr_timer_ctrl #(
    .DIV1_LOG(DIV1_LOG),
    .DIV2_LOG(DIV2_LOG)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .clkEn     (clkEn),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .cfgData   (wrData[CFG_LSB +: CFG_W]),
    .atTerm    (atTerm),
    .lfsrHit   (lfsrHit),
    .lfsrZero  (lfsrZero),
    .cmd       (cmd),
    .irqOut    (irqOut),
    .resetPulse(resetPulse)
  );

  wdog_lfsr_timer_dp #(
    .CNT_W(CNT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .wrData  (wrData),
    .countVal(countVal),
    .atTerm  (atTerm),
    .lfsrHit (lfsrHit),
    .lfsrZero(lfsrZero)
  );

endmodule

// File: tb/wdog_lfsr_timer_tb.sv
module wdog_lfsr_timer_tb;

  localparam int CW = 8;
  localparam int MAXV = (1 << CW) - 1;

  bit clk = 1'b0;
  bit rstN = 1'b0;
  bit clkEn = 1'b1;
  bit gateEn = 1'b0;
  bit wrEn = 1'b0;
  bit [1:0] wrSel = 2'd0;
  bit [15:0] wrData = 16'd0;
  logic [CW-1:0] countVal;
  logic irqOut, resetPulse;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;
  string curReq = "R1";

  wdog_lfsr_timer #(.CNT_W(CW)) u_dut (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .wrEn(wrEn), .wrSel(wrSel),
    .wrData(wrData), .countVal(countVal), .irqOut(irqOut), .resetPulse(resetPulse)
  );

  always #10 clk = ~clk;  // 50 MHz

  always @(negedge clk) clkEn <= gateEn ? ~clkEn : 1'b1;

  // Behavioural reference model
  int mCfg, mLoad, mCnt, mLfsr, mPre, mIrq, mRst;
  int en, up, per, wd, sec, ps, iop, wdA, atT, tk, to, kick, good, bad, ex, setI;
  int cw, lw, kw;

  function automatic int lfsrStep(int s);
    int n = (s << 1) & 255;
    if ((s & 128) != 0) n = n ^ 8'h63;
    return n;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCfg = 0; mLoad = 0; mCnt = 0; mLfsr = 0; mPre = 0; mIrq = 0; mRst = 0;
    end else begin
      up  = (mCfg >> 8) & 1; en = (mCfg >> 7) & 1; per = (mCfg >> 6) & 1;
      wd  = (mCfg >> 5) & 1; sec = (mCfg >> 4) & 1; ps = (mCfg >> 2) & 3;
      iop = (mCfg >> 1) & 1;
      cw = int'(wrEn && wrSel == 0); lw = int'(wrEn && wrSel == 1);
      kw = int'(wrEn && wrSel == 2);
      wdA = en & wd;
      atT = up ? int'(mCnt == MAXV) : int'(mCnt == 0);
      tk = 0;
      if (!cw && en && clkEn)
        tk = (ps == 1) ? int'(mPre % 16 == 15) : (ps == 2) ? int'(mPre == 255) : 1;
      to = tk & atT;
      kick = kw & wdA;
      good = kick & int'(sec == 0 || (mLfsr != 0 && int'(wrData & 255) == mLfsr));
      bad = kick & int'(!good);
      ex = to & wdA & int'(!good);
      setI = (to & int'(!wdA)) | (ex & iop);
      mRst = bad | (ex & int'(!iop));
      if (setI) mIrq = 1; else if (kw) mIrq = 0;
      if (lw) begin mLoad = int'(wrData) & MAXV; mCnt = mLoad; end
      else if (good || (to && (per || wdA))) mCnt = mLoad;
      else if (tk) mCnt = up ? (mCnt + 1) & MAXV : (mCnt + MAXV) & MAXV;
      if (kw && !wdA) mLfsr = int'(wrData) & 255;
      else if (good && sec) mLfsr = lfsrStep(mLfsr);
      mPre = (cw || !en) ? 0 : clkEn ? (mPre + 1) % 256 : mPre;
      if (cw) mCfg = int'(wrData) & 'h1FE;
    end
  end

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done) begin
      vectors++;
      if (int'(countVal) != mCnt || int'(irqOut) != mIrq || int'(resetPulse) != mRst) begin
        fails++;
        $display("FAIL %s: cnt/irq/rst actual %0d/%0d/%0d expected %0d/%0d/%0d",
                 curReq, countVal, irqOut, resetPulse, mCnt, mIrq, mRst);
      end
    end
  end

  task automatic chk(string req, int act, int expv);
    vectors++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic wr(int sel, int data);
    @(negedge clk);
    wrEn = 1'b1; wrSel = 2'(sel); wrData = 16'(data);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    curReq = "R1";
    chk("R1", int'(countVal), 0); chk("R1", int'(irqOut), 0); chk("R1", int'(resetPulse), 0);

    curReq = "R13";  // load while disabled, count holds
    wr(1, 5); idle(10);
    chk("R13", int'(countVal), 5);
    curReq = "R2"; wr(3, 9); idle(2);
    chk("R2", int'(countVal), 5);

    curReq = "R6";  // down, periodic, /1
    wr(0, 'h0C0); idle(20);
    chk("R6", int'(irqOut), 1);
    wr(2, 0); chk("R6", int'(irqOut), 0);
    for (int i = 0; i < 6; i++) begin idle(5); wr(2, 0); end

    curReq = "R5";  // free-running down wrap
    wr(0, 'h080); idle(300);
    curReq = "R4";  // up, periodic
    wr(1, 'hF0); wr(0, 'h1C0); idle(40);
    curReq = "R5"; wr(0, 'h180); idle(280);

    curReq = "R3";  // prescale variants
    wr(1, 3); gateEn = 1'b1; wr(0, 'h0C4); idle(300);
    gateEn = 1'b0; wr(0, 'h0C8); idle(1300);
    wr(0, 'h0CC); idle(20);

    curReq = "R8";  // plain watchdog, reset on expiry
    wr(0, 0); wr(2, 0); wr(1, 20); wr(0, 'h0E0);
    for (int i = 0; i < 6; i++) begin idle(8); wr(2, 0); chk("R8", int'(countVal), 20); end
    curReq = "R7"; idle(40);
    wr(0, 'h0E2); idle(30);
    chk("R7", int'(irqOut), 1);
    curReq = "R8"; wr(2, 0); chk("R8", int'(irqOut), 0);

    curReq = "R10";  // hardened kicks
    wr(0, 0); wr(2, 'hAA); wr(1, 30); wr(0, 'h0F0);
    idle(3); wr(2, 'hAA); chk("R10", int'(resetPulse), 0); chk("R10", int'(countVal), 30);
    idle(3); wr(2, 'h37); chk("R10", int'(resetPulse), 0);
    idle(3); wr(2, 'h6E); chk("R10", int'(resetPulse), 0);
    curReq = "R11";
    idle(3); wr(2, 'h66); chk("R11", int'(resetPulse), 1);
    idle(3); wr(2, 'hDC); chk("R10", int'(resetPulse), 0);
    idle(50);

    curReq = "R12";  // zero seed
    wr(0, 0); wr(2, 0); wr(0, 'h0F0);
    idle(2); wr(2, 0); chk("R12", int'(resetPulse), 1);
    idle(4); wr(2, 'h55); chk("R12", int'(resetPulse), 1);
    idle(40);

    curReq = "R9";  // seed while inactive, then accepted kick
    wr(0, 0); wr(2, 'h81); wr(0, 'h0F0);
    idle(2); wr(2, 'h81); chk("R9", int'(resetPulse), 0);
    idle(2); wr(2, lfsrStep('h81)); chk("R10", int'(resetPulse), 0);
    idle(5);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    done = 1'b1;
    fails++;
    $display("FAIL watchdog (all requirements): actual 200000 cycles expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule